// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Engine

This block models the write path of a byte-wide nonvolatile memory that is programmed one whole page at a time. A host uses active-low chip-select, read-strobe and write-strobe lines, an address bus and separate data-in and data-out buses to load bytes into a page buffer. The data-out bus carries a drive flag in place of a tri-state buffer. Loading continues for as long as each new byte arrives before a load timeout expires. When the timeout expires, the block enters a timed programming phase. At the end of that phase it writes the whole page into a register-array store in a single step. Offsets that were not loaded in that cycle are written as FFh.

While programming runs, `busy` is high and host writes are ignored. The host can still poll for completion by reading. Bit 7 at the most recently loaded address reads back inverted. Bit 6 at any address changes value after every completed read. All bus inputs are sampled on the rising clock edge. Every time constant is a parameter expressed in clock cycles.

The controller has three states: IDLE, LOAD and PROG. It has four named transitions. *first_byte* goes from IDLE to LOAD on the first accepted byte. *more_bytes* keeps the controller in LOAD while further bytes arrive. *load_timeout* goes from LOAD to PROG when the load timer expires. *prog_done* goes from PROG to IDLE, and at that moment the page is committed and the buffer is cleared.

Top module: `page_write_engine`

## Requirements
- R1: After reset every byte of the store reads FFh, `busy` is low and the state is IDLE.
- R2: `dout_en` is high only when `ce_n` and `oe_n` are both low. Outside programming, `dout` shows the stored byte at `addr`.
- R3: A write pulse is a run of sampled cycles with `ce_n` low, `we_n` low and `oe_n` high. A pulse shorter than MIN_WE cycles loads nothing. Holding `oe_n` low blocks the pulse from starting at all.
- R4: A byte's address is the value of `addr` in the pulse's first sampled cycle. Its data is the value of `din` in the pulse's last sampled cycle.
- R5: Let edge 1 be the first rising edge at which a write pulse is seen released, with no further pulse following it. `busy` is low after edge LOAD_TIMEOUT+1 and high after edge LOAD_TIMEOUT+2.
- R6: `busy` stays high for exactly PROG_CYCLES clock cycles. The store is updated on the edge at which it falls.
- R7: At commit, each loaded offset takes its most recently loaded byte and every other offset of the page becomes FFh. Load order does not matter.
- R8: The page is the address bits above the low 7 offset bits. A byte whose page differs from the page of the first byte in the load cycle is discarded.
- R9: During programming, a read at the last loaded address returns bit 7 inverted from the loaded value. After programming it returns the true byte.
- R10: During programming, bit 6 reads 0 on the first read. It inverts after every completed read and stays steady within a single read.
- R11: Write pulses that begin during programming change no stored byte and do not start a new load cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low read strobe |
| we_n | input | 1 | Active-low write strobe |
| addr | input | OFF_W+PAGE_SEL_W | Byte address: page bits above the offset bits |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, or status while programming |
| dout_en | output | 1 | High when `dout` would be driven onto the bus |
| busy | output | 1 | High during the internal programming phase |

## Verification
Read results are combinational, so the bench samples `dout` one cycle after it asserts the strobes. The toggle flag moves on the edge that follows the release of a read, which lets back-to-back reads show alternating values. `busy` is checked at exact edge counts: low after LOAD_TIMEOUT+1 edges and high after LOAD_TIMEOUT+2 edges, both counted from the release of a write. It is then high after PROG_CYCLES-1 further edges and low after one more. Checks on stored bytes are made only after `busy` has fallen. Ignored stimuli get two follow-ups: `busy` is observed over a window longer than the load timeout, and the addresses that could have been touched are read back.

// File: rtl/pwe_pkg.sv
package pwe_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pwe_state_e;

endpackage

// File: rtl/pwe_pulse_qual.sv
module pwe_pulse_qual #(
    parameter int ADDR_W = 10,
    parameter int MIN_WE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              inhibit,
    output logic              hold,
    output logic              stb,
    output logic [ADDR_W-1:0] stb_addr,
    output logic [7:0]        stb_data
);
    localparam int CW = $clog2(MIN_WE + 1);

    logic          act;
    logic          act_q;
    logic          ok_q;
    logic [CW-1:0] width_q;

    assign act  = ~ce_n & ~we_n & oe_n;
    assign hold = act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q    <= 1'b0;
            ok_q     <= 1'b0;
            width_q  <= '0;
            stb      <= 1'b0;
            stb_addr <= '0;
            stb_data <= '0;
        end else begin
            act_q <= act;
            stb   <= 1'b0;
            if (act && !act_q) begin
                stb_addr <= addr;
                stb_data <= din;
                width_q  <= CW'(1);
                ok_q     <= ~inhibit;
            end else if (act) begin
                stb_data <= din;
                if (width_q < CW'(MIN_WE)) begin
                    width_q <= width_q + CW'(1);
                end
            end else if (act_q) begin
                stb <= ok_q && (width_q >= CW'(MIN_WE));
            end
        end
    end

endmodule

// File: rtl/pwe_page_buffer.sv
module pwe_page_buffer
    import pwe_pkg::*;
#(
    parameter int OFF_W = 7
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clr,
    input  logic                             wr,
    input  logic [OFF_W-1:0]                 wr_off,
    input  byte_t                            wr_data,
    output logic [(1<<OFF_W)-1:0][7:0]       data_o,
    output logic [(1<<OFF_W)-1:0]            valid_o
);
    localparam int PAGE_BYTES = 1 << OFF_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o  <= '0;
            valid_o <= '0;
        end else if (clr) begin
            valid_o <= '0;
        end else if (wr) begin
            data_o[wr_off]  <= wr_data;
            valid_o[wr_off] <= 1'b1;
        end
    end

    logic unused_ok;
    assign unused_ok = (PAGE_BYTES > 0);

endmodule

// File: rtl/page_write_engine.sv
module page_write_engine
    import pwe_pkg::*;
#(
    parameter int OFF_W        = 7,
    parameter int PAGE_SEL_W   = 3,
    parameter int LOAD_TIMEOUT = 64,
    parameter int PROG_CYCLES  = 256,
    parameter int MIN_WE       = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ce_n,
    input  logic                        oe_n,
    input  logic                        we_n,
    input  logic [OFF_W+PAGE_SEL_W-1:0] addr,
    input  logic [7:0]                  din,
    output logic [7:0]                  dout,
    output logic                        dout_en,
    output logic                        busy
);
    localparam int ADDR_W     = OFF_W + PAGE_SEL_W;
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int LT_W       = $clog2(LOAD_TIMEOUT + 1);
    localparam int PC_W       = $clog2(PROG_CYCLES + 1);

    pwe_state_e state_q, state_d;

    byte_t                     mem [DEPTH];
    logic [PAGE_SEL_W-1:0]     page_q;
    logic [OFF_W-1:0]          last_off_q;
    logic [LT_W-1:0]           tcnt_q;
    logic [PC_W-1:0]           pcnt_q;
    logic                      tog_q;
    logic                      rd_q;

    logic                      qual_stb;
    logic                      qual_hold;
    logic [ADDR_W-1:0]         qual_addr;
    byte_t                     qual_data;
    logic [PAGE_BYTES-1:0][7:0] buf_data;
    logic [PAGE_BYTES-1:0]     buf_valid;

    logic                      rd_act;
    logic                      same_page;
    logic                      accept;
    logic                      timeout_hit;
    logic                      prog_done;
    logic [ADDR_W-1:0]         last_addr;
    logic                      poll_bit;

    assign rd_act      = ~ce_n & ~oe_n;
    assign same_page   = (qual_addr[ADDR_W-1:OFF_W] == page_q);
    assign accept      = qual_stb && ((state_q == ST_IDLE) ||
                                      (state_q == ST_LOAD && same_page));
    assign timeout_hit = (state_q == ST_LOAD) && !qual_stb && !qual_hold &&
                         (tcnt_q == LT_W'(LOAD_TIMEOUT - 1));
    assign prog_done   = (state_q == ST_PROG) && (pcnt_q == PC_W'(PROG_CYCLES - 1));
    assign last_addr   = {page_q, last_off_q};
    assign poll_bit    = buf_data[last_off_q][7];

    pwe_pulse_qual #(
        .ADDR_W (ADDR_W),
        .MIN_WE (MIN_WE)
    ) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .addr     (addr),
        .din      (din),
        .inhibit  (state_q == ST_PROG),
        .hold     (qual_hold),
        .stb      (qual_stb),
        .stb_addr (qual_addr),
        .stb_data (qual_data)
    );

    pwe_page_buffer #(
        .OFF_W (OFF_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (prog_done),
        .wr      (accept),
        .wr_off  (qual_addr[OFF_W-1:0]),
        .wr_data (qual_data),
        .data_o  (buf_data),
        .valid_o (buf_valid)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: first_byte, more_bytes, load_timeout, prog_done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)      state_d = ST_LOAD;
            ST_LOAD: if (timeout_hit) state_d = ST_PROG;
            ST_PROG: if (prog_done)   state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // Timers, capture registers and toggle flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q     <= '0;
            last_off_q <= '0;
            tcnt_q     <= '0;
            pcnt_q     <= '0;
            tog_q      <= 1'b0;
            rd_q       <= 1'b0;
        end else begin
            rd_q <= rd_act;
            if (accept) begin
                last_off_q <= qual_addr[OFF_W-1:0];
                if (state_q == ST_IDLE) page_q <= qual_addr[ADDR_W-1:OFF_W];
            end
            if (state_q != ST_LOAD || qual_stb || qual_hold) tcnt_q <= '0;
            else                                             tcnt_q <= tcnt_q + LT_W'(1);
            if (state_q != ST_PROG) pcnt_q <= '0;
            else                    pcnt_q <= pcnt_q + PC_W'(1);
            if (state_q != ST_PROG)    tog_q <= 1'b0;
            else if (rd_q && !rd_act)  tog_q <= ~tog_q;
        end
    end

    // Storage array with whole-page commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (prog_done) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (buf_valid[i]) mem[{page_q, OFF_W'(i)}] <= buf_data[i];
                else              mem[{page_q, OFF_W'(i)}] <= 8'hFF;
            end
        end
    end

    // Outputs
    always_comb begin
        busy    = (state_q == ST_PROG);
        dout_en = rd_act;
        dout    = mem[addr];
        if (busy) begin
            dout[6] = tog_q;
            if (addr == last_addr) dout[7] = ~poll_bit;
        end
    end

endmodule

// File: rtl/pwe_checker.sv
module pwe_checker #(
    parameter int ADDR_W      = 10,
    parameter int PROG_CYCLES = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        dout,
    input logic              dout_en,
    input logic              busy,
    input logic [1:0]        state,
    input logic              stb,
    input logic              poll_bit,
    input logic [ADDR_W-1:0] last_addr
);
    localparam int RW = $clog2(PROG_CYCLES + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + RW'(1);
        else           run_q <= '0;
    end

    a_r6_prog_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == RW'(PROG_CYCLES));

    a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_q < RW'(PROG_CYCLES));

    a_r5_prog_from_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(state) == pwe_pkg::ST_LOAD);

    a_r3_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && state == pwe_pkg::ST_IDLE) |=> state == pwe_pkg::ST_LOAD);

    a_r9_polling: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dout_en && addr == last_addr) |-> dout[7] != poll_bit);

    a_r10_steady_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && dout_en && $past(dout_en) && $stable(addr))
            |-> $stable(dout[6]));

endmodule

bind page_write_engine pwe_checker #(
    .ADDR_W      (OFF_W + PAGE_SEL_W),
    .PROG_CYCLES (PROG_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .dout      (dout),
    .dout_en   (dout_en),
    .busy      (busy),
    .state     (state_q),
    .stb       (qual_stb),
    .poll_bit  (poll_bit),
    .last_addr (last_addr)
);

// File: tb/page_write_engine_bench.sv
module page_write_engine_bench;
    localparam int OFF_W = 7;
    localparam int PSW   = 3;
    localparam int AW    = OFF_W + PSW;
    localparam int LT    = 16;
    localparam int PC    = 24;
    localparam int MINW  = 2;
    localparam int PB    = 1 << OFF_W;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en;
    logic          busy;

    int errors = 0;
    int checks = 0;

    logic [7:0]     mdl [DEPTH];
    logic [7:0]     pbuf [PB];
    logic           pval [PB];
    logic [PSW-1:0] ppage;
    logic           phave;

    always #10 clk = ~clk;

    page_write_engine #(
        .OFF_W(OFF_W), .PAGE_SEL_W(PSW), .LOAD_TIMEOUT(LT),
        .PROG_CYCLES(PC), .MIN_WE(MINW)
    ) u_page_write_engine (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] commit_val(input int off);
        return pval[off] ? pbuf[off] : 8'hFF;
    endfunction

    task automatic model_commit();
        if (phave) begin
            for (int i = 0; i < PB; i++) mdl[{ppage, OFF_W'(i)}] = commit_val(i);
        end
        for (int i = 0; i < PB; i++) pval[i] = 1'b0;
        phave = 1'b0;
    endtask

    task automatic model_load(input logic [AW-1:0] a, input logic [7:0] d);
        if (!phave) begin
            phave = 1'b1;
            ppage = a[AW-1:OFF_W];
        end
        if (a[AW-1:OFF_W] == ppage) begin
            pbuf[a[OFF_W-1:0]] = d;
            pval[a[OFF_W-1:0]] = 1'b1;
        end
    endtask

    task automatic wr_pulse(input logic [AW-1:0] a, input logic [7:0] d, input int w);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        tick(w);
        we_n = 1'b1; ce_n = 1'b1;
        tick(2);
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [7:0] d);
        wr_pulse(a, d, 3);
        model_load(a, d);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v, output logic en);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        tick(1);
        v = dout; en = dout_en;
        ce_n = 1'b1; oe_n = 1'b1;
        tick(1);
    endtask

    task automatic wait_busy(input logic lvl, input string req);
        int n = 0;
        while (busy !== lvl && n < LT + PC + 20) begin
            tick(1);
            n++;
        end
        chk(req, int'(busy), int'(lvl));
    endtask

    task automatic commit_wait();
        wait_busy(1'b1, "R5 busy rises");
        wait_busy(1'b0, "R6 busy falls");
        model_commit();
    endtask

    task automatic check_page(input logic [PSW-1:0] pg, input string req);
        logic [7:0] v;
        logic       en;
        for (int i = 0; i < PB; i++) begin
            rd({pg, OFF_W'(i)}, v, en);
            chk(req, v, mdl[{pg, OFF_W'(i)}]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0]     v;
        logic           en;
        logic [PSW-1:0] rpage;
        int unused_seed;

        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;
        for (int i = 0; i < PB; i++) begin pval[i] = 1'b0; pbuf[i] = 8'h00; end
        phave = 1'b0;
        ppage = '0;
        rpage = '0;
        unused_seed = $urandom(32'h5EED_0042);

        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state, R2 read enable
        chk("R1 busy after reset", int'(busy), 0);
        chk("R2 dout_en idle", int'(dout_en), 0);
        rd('0, v, en);
        chk("R1 first byte erased", v, 8'hFF);
        chk("R2 dout_en during read", int'(en), 1);
        rd(AW'(DEPTH - 1), v, en);
        chk("R1 last byte erased", v, 8'hFF);
        addr = '0; ce_n = 1'b0; oe_n = 1'b1;
        tick(1);
        chk("R2 no drive with oe_n high", int'(dout_en), 0);
        ce_n = 1'b1;
        tick(1);

        // R7 random pages, random offsets in random order
        for (int r = 0; r < 3; r++) begin
            int n;
            rpage = PSW'($urandom % (1 << PSW));
            n = 1 + int'($urandom % 20);
            for (int k = 0; k < n; k++) begin
                load({rpage, OFF_W'($urandom % PB)}, 8'($urandom));
            end
            commit_wait();
            check_page(rpage, "R7 random page commit");
        end

        // R5/R6 exact timing, R7 unloaded offsets become FF
        load({rpage, 7'd5}, 8'h3C);
        tick(LT - 1);
        chk("R5 busy low at timeout edge", int'(busy), 0);
        tick(1);
        chk("R5 busy high one edge later", int'(busy), 1);
        tick(PC - 1);
        chk("R6 busy still high", int'(busy), 1);
        tick(1);
        chk("R6 busy low after PROG_CYCLES", int'(busy), 0);
        model_commit();
        check_page(rpage, "R7 partial page refill");

        // R9 polling, R10 toggle, R11 write during busy
        load({3'd1, 7'd9}, 8'h5A);
        load({3'd1, 7'd10}, 8'h81);
        wait_busy(1'b1, "R5 busy rises");
        rd({3'd1, 7'd10}, v, en);
        chk("R9 bit7 inverted", int'(v[7]), 0);
        chk("R10 first read bit6", int'(v[6]), 0);
        rd({3'd1, 7'd10}, v, en);
        chk("R10 second read bit6", int'(v[6]), 1);
        rd({3'd1, 7'd9}, v, en);
        chk("R10 third read bit6", int'(v[6]), 0);
        chk("R9 other address bit7", int'(v[7]), int'(mdl[{3'd1, 7'd9}][7]));
        wr_pulse({3'd5, 7'd0}, 8'h12, 3);
        wait_busy(1'b0, "R6 busy falls");
        model_commit();
        rd({3'd1, 7'd10}, v, en);
        chk("R9 true data after programming", v, 8'h81);
        tick(LT + 4);
        chk("R11 no load started by busy write", int'(busy), 0);
        rd({3'd5, 7'd0}, v, en);
        chk("R11 busy write ignored", v, mdl[{3'd5, 7'd0}]);

        // R3 short pulse ignored
        wr_pulse({3'd6, 7'd3}, 8'h44, 1);
        tick(LT + 4);
        chk("R3 short pulse no busy", int'(busy), 0);
        rd({3'd6, 7'd3}, v, en);
        chk("R3 short pulse no change", v, mdl[{3'd6, 7'd3}]);

        // R3 oe_n low inhibits
        addr = {3'd6, 7'd4}; din = 8'h55; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        tick(3);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        tick(LT + 4);
        chk("R3 oe_n low no busy", int'(busy), 0);
        rd({3'd6, 7'd4}, v, en);
        chk("R3 oe_n low no change", v, mdl[{3'd6, 7'd4}]);

        // R4 address from first cycle, data from last cycle
        addr = {3'd2, 7'd20}; din = 8'hA1; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        tick(1);
        addr = {3'd2, 7'd21}; din = 8'hB2;
        tick(2);
        we_n = 1'b1; ce_n = 1'b1;
        tick(2);
        model_load({3'd2, 7'd20}, 8'hB2);
        commit_wait();
        rd({3'd2, 7'd20}, v, en);
        chk("R4 captured byte", v, 8'hB2);
        rd({3'd2, 7'd21}, v, en);
        chk("R4 later address not written", v, 8'hFF);

        // R8 foreign page discarded, R7 last load wins
        load({3'd3, 7'd1}, 8'h77);
        load({3'd4, 7'd2}, 8'h22);
        load({3'd3, 7'd1}, 8'h11);
        commit_wait();
        rd({3'd3, 7'd1}, v, en);
        chk("R7 last load wins", v, 8'h11);
        rd({3'd4, 7'd2}, v, en);
        chk("R8 foreign page byte dropped", v, mdl[{3'd4, 7'd2}]);
        check_page(3'd3, "R8 own page intact");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule